// File: doc/BRIEF.md
# Iterative SHA-1 Compression Core

This block applies the SHA-1 compression function to one 512-bit message block that has already been padded. It does not unroll all eighty rounds into a single cycle. A round counter steps through the loop instead, and a parameter sets how many rounds are chained inside each cycle. With one round per cycle, the logic between registers is a single round. With forty rounds per cycle, the whole block finishes in two round cycles but with a much deeper path. Once the last round is done, a separate fold step adds the five working words into the five chaining words. A second parameter can place a register stage on those five sums, so the adders are split from the chaining register at the cost of one extra cycle.

A host puts a block on `block`, selects whether the run starts from the standard initial value (`use_iv` high) or from the digest the core already holds (`use_iv` low), and pulses `start`. While the core computes, `busy` is high. When the new digest is in place, `done` pulses for one cycle. A long message is hashed by starting its first block with `use_iv` high and every later block with `use_iv` low.

Top module: `sha1_iter_core`

## Requirements
- R1: After reset, `busy` and `done` are low and `digest` is all zeros.
- R2: When `start` is high while `busy` is low, the run is accepted at that clock edge, and `busy` is high from the next cycle.
- R3: For an accepted run, `busy` stays high for exactly ROUNDS/ROUNDS_PER_CYCLE + 1 + FEEDBACK_REG cycles, where ROUNDS = 80. With the default parameters (1, 0) this is 81 cycles.
- R4: `done` is high for exactly one cycle, and that cycle is the first one with `busy` low. In that cycle `digest` already holds the new result.
- R5: With `use_iv` = 1 the run starts from h0..h4 = 67452301, EFCDAB89, 98BADCFE, 10325476, C3D2E1F0. For the padded one-block message "abc" (words 61626380, fourteen zero words, 00000018) the digest is a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R6: With `use_iv` = 0 the run starts from the digest currently held. The two-block message "abcdbcdecdef...nopq" (56 bytes) ends at 84983e44 1c3bd26e baae4aa1 f95129e5 e54670f1.
- R7: A `start` pulse while `busy` is high is ignored. The running computation is neither restarted nor altered, and it finishes at its original time with its original result.
- R8: `digest` does not change across a clock edge at which `busy` is high both before and after the edge.
- R9: A `start` pulse in the cycle where `done` is high is accepted like any start from idle.
- R10: The round functions and constants switch every 20 rounds: choose with 5A827999, parity with 6ED9EBA1, majority with 8F1BBCDC, parity with CA62C1D6. For t ≥ 16 the schedule is W[t] = rotl1(W[t-3]^W[t-8]^W[t-14]^W[t-16]). Each round computes rotl5(A)+f+E+K+W[t] into A, moves A to B, rotl30(B) to C, C to D and D to E. All sums wrap modulo 2^32.
- R11: `block[511:480]` is W[0] and `block[31:0]` is W[15]. `digest[159:128]` is h0 and `digest[31:0]` is h4.
- R12: ROUNDS_PER_CYCLE must divide 80, and FEEDBACK_REG is 0 or 1; other values fail elaboration. ROUNDS_PER_CYCLE = 40 with FEEDBACK_REG = 1 gives a 4-cycle busy window and the same digests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a compression run when idle |
| use_iv | input | 1 | 1: start from the standard initial value; 0: chain from the held digest |
| block | input | 512 | Padded message block, W[0] in the top bits |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the new digest is ready |
| digest | output | 160 | Chaining value h0..h4, h0 in the top bits |

## Verification
The collision that matters is a new `start` arriving in the same cycle as `done`. In that cycle the fold of one run has just finished and the load of the next run must accept it, using the just-committed digest as its chaining input. The bench provokes this by watching for `done` on the one-round-per-cycle instance and raising `start` with `use_iv` low in that same cycle. It then judges the second digest against a bench-computed compression of the first result. A second case pulses `start` in the middle of a run, which must leave that run's timing and result untouched.

// File: rtl/sha1_pkg.sv
`timescale 1ns/1ps
package sha1_pkg;
   localparam int WORD_W = 32;
   localparam int ROUNDS = 80;
   localparam int IDX_W  = 7;
   localparam int SCHED_N = 16;
   localparam int STAGE_LEN = 20;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [IDX_W-1:0]  ridx_t;

   typedef struct packed {
      word_t a;
      word_t b;
      word_t c;
      word_t d;
      word_t e;
   } state_t;

   typedef word_t [SCHED_N-1:0] sched_t;

   localparam state_t IV = '{a: 32'h67452301, b: 32'hEFCDAB89, c: 32'h98BADCFE,
                             d: 32'h10325476, e: 32'hC3D2E1F0};

   function automatic word_t rotl(input word_t x, input int n);
      return (x << n) | (x >> (WORD_W - n));
   endfunction

   function automatic word_t round_mix(input ridx_t t, input word_t b, input word_t c,
                                       input word_t d);
      if (t < ridx_t'(STAGE_LEN))
         return (b & c) | (~b & d);
      else if (t < ridx_t'(2*STAGE_LEN))
         return b ^ c ^ d;
      else if (t < ridx_t'(3*STAGE_LEN))
         return (b & c) | (b & d) | (c & d);
      else
         return b ^ c ^ d;
   endfunction

   function automatic word_t round_const(input ridx_t t);
      if (t < ridx_t'(STAGE_LEN))        return 32'h5A827999;
      else if (t < ridx_t'(2*STAGE_LEN)) return 32'h6ED9EBA1;
      else if (t < ridx_t'(3*STAGE_LEN)) return 32'h8F1BBCDC;
      else                               return 32'hCA62C1D6;
   endfunction
endpackage

// File: rtl/sha1_round.sv
`timescale 1ns/1ps
module sha1_round
   import sha1_pkg::*;
(
   input  ridx_t  t_idx,
   input  state_t s_in,
   input  sched_t w_in,
   output state_t s_out,
   output sched_t w_out
);
   word_t mix_w;
   word_t sum_w;
   word_t next_w;

   always_comb begin
      mix_w = round_mix(t_idx, s_in.b, s_in.c, s_in.d);
      sum_w = rotl(s_in.a, 5) + mix_w + s_in.e + round_const(t_idx) + w_in[0];
      s_out = '{a: sum_w, b: s_in.a, c: rotl(s_in.b, 30), d: s_in.c, e: s_in.d};
   end

   always_comb begin
      next_w = rotl(w_in[13] ^ w_in[8] ^ w_in[2] ^ w_in[0], 1);
      for (int i = 0; i < SCHED_N - 1; i++)
         w_out[i] = w_in[i+1];
      w_out[SCHED_N-1] = next_w;
   end
endmodule

// File: rtl/sha1_round_chain.sv
`timescale 1ns/1ps
module sha1_round_chain
   import sha1_pkg::*;
#(
   parameter int RPC = 1
)(
   input  ridx_t  t_base,
   input  state_t s_in,
   input  sched_t w_in,
   output state_t s_out,
   output sched_t w_out
);
   state_t st_w [RPC+1];
   sched_t sc_w [RPC+1];

   assign st_w[0] = s_in;
   assign sc_w[0] = w_in;

   for (genvar k = 0; k < RPC; k++) begin : g_rnd
      localparam ridx_t OFF = ridx_t'(k);
      sha1_round u_round (
         .t_idx (t_base + OFF),
         .s_in  (st_w[k]),
         .w_in  (sc_w[k]),
         .s_out (st_w[k+1]),
         .w_out (sc_w[k+1])
      );
   end

   assign s_out = st_w[RPC];
   assign w_out = sc_w[RPC];
endmodule

// File: rtl/sha1_fold.sv
`timescale 1ns/1ps
module sha1_fold
   import sha1_pkg::*;
#(
   parameter int FB_REG = 0
)(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   cap_en,
   input  state_t h_in,
   input  state_t w_in,
   output state_t sum_out
);
   state_t sum_c;

   always_comb begin
      sum_c.a = h_in.a + w_in.a;
      sum_c.b = h_in.b + w_in.b;
      sum_c.c = h_in.c + w_in.c;
      sum_c.d = h_in.d + w_in.d;
      sum_c.e = h_in.e + w_in.e;
   end

   if (FB_REG != 0) begin : g_staged
      state_t t_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      t_q <= '0;
         else if (cap_en) t_q <= sum_c;
      end
      assign sum_out = t_q;
   end else begin : g_direct
      logic unused_fold;
      assign unused_fold = ^{clk, rst_n, cap_en};
      assign sum_out = sum_c;
   end
endmodule

// File: rtl/sha1_ctrl.sv
`timescale 1ns/1ps
module sha1_ctrl
   import sha1_pkg::*;
#(
   parameter int RPC = 1,
   parameter int FB  = 0
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   output logic  busy,
   output logic  accept,
   output logic  advance,
   output logic  fold_cap,
   output logic  commit,
   output logic  done,
   output ridx_t rnd_idx
);
   localparam ridx_t STEP     = ridx_t'(RPC);
   localparam ridx_t LAST_IDX = ridx_t'(ROUNDS - RPC);

   typedef enum logic [1:0] {C_IDLE, C_ROUND, C_FOLD, C_COPY} cst_e;

   cst_e  st_q;
   ridx_t rnd_q;
   logic  done_q;

   assign busy     = (st_q != C_IDLE);
   assign accept   = (st_q == C_IDLE) && start;
   assign advance  = (st_q == C_ROUND);
   assign fold_cap = (st_q == C_FOLD);
   assign commit   = (FB != 0) ? (st_q == C_COPY) : (st_q == C_FOLD);
   assign done     = done_q;
   assign rnd_idx  = rnd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= C_IDLE;
         rnd_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= commit;
         case (st_q)
            C_IDLE: if (start) begin
               rnd_q <= '0;
               st_q  <= C_ROUND;
            end
            C_ROUND: begin
               rnd_q <= rnd_q + STEP;
               if (rnd_q == LAST_IDX) st_q <= C_FOLD;
            end
            C_FOLD:  st_q <= (FB != 0) ? C_COPY : C_IDLE;
            C_COPY:  st_q <= C_IDLE;
            default: st_q <= C_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sha1_iter_core.sv
`timescale 1ns/1ps
module sha1_iter_core
   import sha1_pkg::*;
#(
   parameter int ROUNDS_PER_CYCLE = 1,
   parameter int FEEDBACK_REG     = 0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         use_iv,
   input  logic [511:0] block,
   output logic         busy,
   output logic         done,
   output logic [159:0] digest
);
   localparam int BLK_W = SCHED_N * WORD_W;

   if (ROUNDS_PER_CYCLE < 1 || (ROUNDS % ROUNDS_PER_CYCLE) != 0) begin : g_bad_rpc
      $error("ROUNDS_PER_CYCLE must divide the round count");
   end
   if (FEEDBACK_REG != 0 && FEEDBACK_REG != 1) begin : g_bad_fb
      $error("FEEDBACK_REG must be 0 or 1");
   end

   logic   accept, advance, fold_cap, commit;
   ridx_t  rnd_idx;
   state_t hash_q, work_q, base_c, work_nx, sum_w;
   sched_t sched_q, sched_ld, sched_nx;

   sha1_ctrl #(.RPC(ROUNDS_PER_CYCLE), .FB(FEEDBACK_REG)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .busy     (busy),
      .accept   (accept),
      .advance  (advance),
      .fold_cap (fold_cap),
      .commit   (commit),
      .done     (done),
      .rnd_idx  (rnd_idx)
   );

   sha1_round_chain #(.RPC(ROUNDS_PER_CYCLE)) u_chain (
      .t_base (rnd_idx),
      .s_in   (work_q),
      .w_in   (sched_q),
      .s_out  (work_nx),
      .w_out  (sched_nx)
   );

   sha1_fold #(.FB_REG(FEEDBACK_REG)) u_fold (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (fold_cap),
      .h_in    (hash_q),
      .w_in    (work_q),
      .sum_out (sum_w)
   );

   always_comb begin
      base_c = use_iv ? IV : hash_q;
      for (int i = 0; i < SCHED_N; i++)
         sched_ld[i] = block[BLK_W-1-WORD_W*i -: WORD_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hash_q  <= '0;
         work_q  <= '0;
         sched_q <= '0;
      end else if (accept) begin
         hash_q  <= base_c;
         work_q  <= base_c;
         sched_q <= sched_ld;
      end else begin
         if (advance) begin
            work_q  <= work_nx;
            sched_q <= sched_nx;
         end
         if (commit) hash_q <= sum_w;
      end
   end

   assign digest = hash_q;
endmodule

// File: rtl/sha1_iter_core_chk.sv
`timescale 1ns/1ps
module sha1_iter_core_chk #(
   parameter int RPC = 1,
   parameter int FB  = 0
)(
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic [159:0] digest,
   input logic [6:0]   rnd_idx
);
   localparam int LAT = 80 / RPC + 1 + FB;

   logic [7:0] busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 8'd1;
      else           busy_len <= '0;
   end

   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R3 and R7: a run lasts the full window, so a start during it cannot restart it
   a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_len == 8'(LAT)));

   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r8_digest_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(digest));

   a_r12_round_range: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_idx <= 7'd80);
endmodule

bind sha1_iter_core sha1_iter_core_chk #(.RPC(ROUNDS_PER_CYCLE), .FB(FEEDBACK_REG)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .digest  (digest),
   .rnd_idx (rnd_idx)
);

// File: tb/sha1_iter_core_bench.sv
`timescale 1ns/1ps
module sha1_iter_core_bench;
   localparam int LAT0 = 80 / 1 + 1 + 0;
   localparam int LAT1 = 80 / 40 + 1 + 1;
   localparam logic [159:0] IV_H = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic use_iv = 1'b0;
   logic [511:0] blk = '0;

   logic         d_busy [2];
   logic         d_done [2];
   logic [159:0] d_dig  [2];

   logic         m_busy [2];
   logic         m_done [2];
   logic [159:0] m_dig  [2];
   logic [159:0] m_pend [2];
   int           m_rem  [2];

   int chk = 0, err = 0, cchk = 0, cerr = 0;

   always #4 clk = ~clk;

   sha1_iter_core u_sha1_iter_core (
      .clk(clk), .rst_n(rst_n), .start(start), .use_iv(use_iv), .block(blk),
      .busy(d_busy[0]), .done(d_done[0]), .digest(d_dig[0])
   );

   sha1_iter_core #(.ROUNDS_PER_CYCLE(40), .FEEDBACK_REG(1)) u_sha1_iter_core_wide (
      .clk(clk), .rst_n(rst_n), .start(start), .use_iv(use_iv), .block(blk),
      .busy(d_busy[1]), .done(d_done[1]), .digest(d_dig[1])
   );

   function automatic logic [159:0] ref_compress(input logic [159:0] hin, input logic [511:0] b);
      logic [31:0] w [80];
      logic [31:0] a, bb, c, d, e, f, k, tmp, x;
      for (int t = 0; t < 16; t++) w[t] = b[511-32*t -: 32];
      for (int t = 16; t < 80; t++) begin
         x = w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16];
         w[t] = {x[30:0], x[31]};
      end
      a = hin[159:128]; bb = hin[127:96]; c = hin[95:64]; d = hin[63:32]; e = hin[31:0];
      for (int t = 0; t < 80; t++) begin
         if (t < 20)      begin f = (bb & c) | (~bb & d);          k = 32'h5A827999; end
         else if (t < 40) begin f = bb ^ c ^ d;                    k = 32'h6ED9EBA1; end
         else if (t < 60) begin f = (bb & c) | (bb & d) | (c & d); k = 32'h8F1BBCDC; end
         else             begin f = bb ^ c ^ d;                    k = 32'hCA62C1D6; end
         tmp = {a[26:0], a[31:27]} + f + e + k + w[t];
         e = d; d = c; c = {bb[1:0], bb[31:2]}; bb = a; a = tmp;
      end
      return {hin[159:128] + a, hin[127:96] + bb, hin[95:64] + c, hin[63:32] + d, hin[31:0] + e};
   endfunction

   // cycle model: one result per accepted start, fixed latency per variant
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int v = 0; v < 2; v++) begin
            m_busy[v] <= 1'b0; m_done[v] <= 1'b0; m_dig[v] <= '0; m_pend[v] <= '0; m_rem[v] <= 0;
         end
      end else begin
         for (int v = 0; v < 2; v++) begin
            m_done[v] <= 1'b0;
            if (!m_busy[v]) begin
               if (start) begin
                  m_dig[v]  <= use_iv ? IV_H : m_dig[v];
                  m_pend[v] <= ref_compress(use_iv ? IV_H : m_dig[v], blk);
                  m_rem[v]  <= (v == 0) ? LAT0 : LAT1;
                  m_busy[v] <= 1'b1;
               end
            end else if (m_rem[v] == 1) begin
               m_busy[v] <= 1'b0;
               m_done[v] <= 1'b1;
               m_dig[v]  <= m_pend[v];
            end else begin
               m_rem[v] <= m_rem[v] - 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         for (int v = 0; v < 2; v++) begin
            cchk += 3;
            if (d_busy[v] !== m_busy[v]) begin
               cerr++; $display("FAIL R2 busy v%0d actual=%b expected=%b", v, d_busy[v], m_busy[v]);
            end
            if (d_done[v] !== m_done[v]) begin
               cerr++; $display("FAIL R4 done v%0d actual=%b expected=%b", v, d_done[v], m_done[v]);
            end
            if (d_dig[v] !== m_dig[v]) begin
               cerr++; $display("FAIL R8 digest v%0d actual=%h expected=%h", v, d_dig[v], m_dig[v]);
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [159:0] act, input logic [159:0] exp);
      chk++;
      if (!ok) begin
         err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_idle();
      while (d_busy[0] || d_busy[1]) @(negedge clk);
   endtask

   task automatic launch(input bit iv, input logic [511:0] b);
      wait_idle();
      use_iv = iv; blk = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done0();
      while (!d_done[0]) @(negedge clk);
   endtask

   function automatic logic [511:0] rand_block();
      logic [511:0] r;
      for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
      return r;
   endfunction

   localparam logic [511:0] ABC_BLK = {32'h61626380, {14{32'h0}}, 32'h00000018};
   localparam logic [159:0] ABC_DIG = 160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d;
   localparam logic [511:0] L1_BLK = {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
                                      32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
                                      32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
                                      32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
   localparam logic [511:0] L2_BLK = {{15{32'h0}}, 32'h000001c0};
   localparam logic [159:0] L_DIG  = 160'h84983e44_1c3bd26e_baae4aa1_f95129e5_e54670f1;

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", chk + cchk + 1, err + cerr + 1);
      $finish;
   end

   initial begin
      int lat0, lat1;
      bit seen0, seen1, iv;
      logic [511:0] bx, by, bq;
      logic [159:0] prev0, prev1, e0, e1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int v = 0; v < 2; v++) begin
         check(d_busy[v] === 1'b0 && d_done[v] === 1'b0, "R1 flags after reset",
               {158'd0, d_busy[v], d_done[v]}, '0);
         check(d_dig[v] === '0, "R1 digest after reset", d_dig[v], '0);
      end

      // R3 / R12 latency and R5 known vector (R11 word order)
      launch(1'b1, ABC_BLK);
      lat0 = 0; lat1 = 0; seen0 = 0; seen1 = 0;
      while (!seen0) begin
         if (d_done[0]) seen0 = 1; else if (d_busy[0]) lat0++;
         if (!seen1) begin if (d_done[1]) seen1 = 1; else if (d_busy[1]) lat1++; end
         if (!seen0) @(negedge clk);
      end
      check(lat0 == LAT0, "R3 busy cycles", 160'(lat0), 160'(LAT0));
      check(lat1 == LAT1, "R12 busy cycles wide", 160'(lat1), 160'(LAT1));
      check(d_dig[0] === ABC_DIG, "R5 R11 abc digest", d_dig[0], ABC_DIG);
      check(d_dig[1] === ABC_DIG, "R12 abc digest wide", d_dig[1], ABC_DIG);

      // R6 chaining across two blocks
      launch(1'b1, L1_BLK); wait_done0();
      launch(1'b0, L2_BLK); wait_done0();
      check(d_dig[0] === L_DIG, "R6 two-block digest", d_dig[0], L_DIG);
      check(d_dig[1] === L_DIG, "R6 two-block digest wide", d_dig[1], L_DIG);

      // R7 start while busy is ignored
      bx = rand_block(); by = rand_block();
      launch(1'b1, bx);
      repeat (10) @(negedge clk);
      check(d_busy[0] === 1'b1, "R7 still busy before pulse", {159'd0, d_busy[0]}, 160'd1);
      blk = by; start = 1'b1; @(negedge clk); start = 1'b0;
      wait_done0();
      e0 = ref_compress(IV_H, bx);
      check(d_dig[0] === e0, "R7 result unchanged", d_dig[0], e0);
      wait_idle();

      // R9 start in the done cycle
      launch(1'b0, rand_block());
      wait_done0();
      prev0 = d_dig[0]; bq = rand_block();
      use_iv = 1'b0; blk = bq; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(d_busy[0] === 1'b1, "R9 accepted in done cycle", {159'd0, d_busy[0]}, 160'd1);
      wait_done0();
      e0 = ref_compress(prev0, bq);
      check(d_dig[0] === e0, "R9 chained digest", d_dig[0], e0);
      wait_idle();

      // R10 random blocks, mixed start points
      for (int n = 0; n < 6; n++) begin
         iv = (n % 3 == 0); by = rand_block();
         prev0 = d_dig[0]; prev1 = d_dig[1];
         e0 = ref_compress(iv ? IV_H : prev0, by);
         e1 = ref_compress(iv ? IV_H : prev1, by);
         launch(iv, by); wait_done0(); wait_idle();
         check(d_dig[0] === e0, "R10 random digest", d_dig[0], e0);
         check(d_dig[1] === e1, "R10 random digest wide", d_dig[1], e1);
      end

      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", chk + cchk, err + cerr);
      $finish;
   end
endmodule